// File: doc/BRIEF.md
# Windowed Watchdog Timer with Selectable Configuration Source

This block is a windowed watchdog built around a 14-bit down-counter. The counter steps once per tick of a prescaler that divides the peripheral clock. Software must service the watchdog with a two-write refresh sequence, and only while the count sits inside a programmable window. Three events count as a fault: the counter running out, a refresh outside the window, or a malformed sequence. On a fault the block raises a one-cycle reset request or a one-cycle interrupt request, whichever is selected.

The configuration has two possible sources, picked by a start-mode input. The first is a boot-option word that is captured once after reset; in this mode counting starts on its own. The second is a control register that software writes; in this mode counting starts at the first completed refresh sequence. The configuration covers the period, the clock division, the window bounds and the choice of fault output. The current count can be read back at any time through a status register.

Top module: `winwdt`

## Requirements
- R1: When `boot_sel_i` is 0 (auto mode), the block captures `boot_cfg_i` on the first clock after reset release and then starts counting without software action. Later changes on `boot_cfg_i` have no effect, and writes to the control register (address 1) are ignored. Reading address 1 returns the configuration in effect.
- R2: When `boot_sel_i` is 1 (register mode), the control register at address 1 accepts writes until the first completed refresh sequence. That sequence starts counting. Later control writes are ignored until the next reset.
- R3: The control word and the boot word share one layout: bits [1:0] period, [5:2] division, [7:6] window end, [9:8] window start, and bit 10 fault select. Period codes 00/01/10/11 give 1024/4096/8192/16384 ticks. The reload value is the period minus one (0FFFh for code 01). While the counter is stopped, the status count reads the reload value.
- R4: Division codes 0001/0100/1111/0110/0111/1000 give one tick every 4/64/128/512/2048/8192 clocks. Any other code holds the count unchanged.
- R5: A refresh is a write of 0000h to address 0 followed by a write of 00FFh to address 0. Writes to other addresses may come between the two. A valid refresh reloads the counter and restarts the prescaler.
- R6: With P the period and Q = P/4, a refresh is valid only when end ≤ count < start. The start bound for window-start codes 00/01/10/11 is Q, 2Q, 3Q or P. The end bound for window-end codes 00/01/10/11 is 3Q, 2Q, Q or 0.
- R7: After counting has started, each of the following is a refresh error: a completed sequence outside the window, 00FFh without a preceding 0000h, or any other value written to address 0. A refresh error raises a fault and sets status bit 15.
- R8: A tick while the count is 0 is an underflow. It raises a fault, reloads the counter and sets status bit 14.
- R9: The fault output appears one cycle after the event as a one-cycle pulse. It drives `irq_o` when fault select is 1 and `rst_o` when it is 0, and never both together.
- R10: The status count at address 2, bits [13:0], changes only on a tick or a reload. Between two ticks it is stable, and each tick lowers it by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel_i | input | 1 | Start mode: 0 = auto mode from boot word, 1 = register mode |
| boot_cfg_i | input | 11 | Boot-option configuration word (R3 layout) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 refresh, 1 control, 2 status |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| rst_o | output | 1 | One-cycle reset request on a fault |
| irq_o | output | 1 | One-cycle interrupt request on a fault |

## Verification
The assertions check the following on every cycle:
- the count moves only on a tick, a reload or while stopped;
- the counter holds at its reload value after an underflow;
- the configuration in effect never changes once counting has started;
- the sequencer becomes armed only after a 0000h write;
- the two fault outputs are never active together.

Other behaviours need a stimulus and a timed observation, so only the bench scenarios can show them:
- the absolute timeout length for a given period and division;
- the window bounds on both edges;
- the ignored control writes in each mode;
- the stopped counter for a reserved division code.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  localparam int CNT_W = 14;
  localparam int PRE_W = 13;
  localparam int CFG_W = 11;

  typedef struct packed {
    logic       fault_irq;
    logic [1:0] win_start;
    logic [1:0] win_end;
    logic [3:0] div_sel;
    logic [1:0] period_sel;
  } wdt_cfg_t;

  function automatic logic [CNT_W:0] period_ticks(input logic [1:0] sel);
    case (sel)
      2'b00:   period_ticks = (CNT_W+1)'(1024);
      2'b01:   period_ticks = (CNT_W+1)'(4096);
      2'b10:   period_ticks = (CNT_W+1)'(8192);
      default: period_ticks = (CNT_W+1)'(16384);
    endcase
  endfunction

  function automatic logic [PRE_W:0] div_ratio(input logic [3:0] sel);
    case (sel)
      4'b0001: div_ratio = (PRE_W+1)'(4);
      4'b0100: div_ratio = (PRE_W+1)'(64);
      4'b1111: div_ratio = (PRE_W+1)'(128);
      4'b0110: div_ratio = (PRE_W+1)'(512);
      4'b0111: div_ratio = (PRE_W+1)'(2048);
      4'b1000: div_ratio = (PRE_W+1)'(8192);
      default: div_ratio = '0;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           clr_i,
  input  logic [PRE_W:0] ratio_i,
  output logic           tick_o
);
  logic [PRE_W-1:0] presc_q, presc_d;
  logic             ratio_ok;

  always_comb begin
    ratio_ok = (ratio_i != '0);
    tick_o   = run_i && ratio_ok && !clr_i && ({1'b0, presc_q} == ratio_i - 1'b1);
    if (clr_i || !run_i || !ratio_ok || tick_o) presc_d = '0;
    else                                        presc_d = presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  // R4: a reserved ratio never produces a tick
  assert_no_tick_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_i == '0) |-> !tick_o);
endmodule

// File: rtl/wdt_refresh_seq.sv
module wdt_refresh_seq #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic              broken_o
);
  localparam logic [DATA_W-1:0] KEY_ARM  = '0;
  localparam logic [DATA_W-1:0] KEY_FIRE = DATA_W'(8'hFF);

  logic armed_q, armed_d;

  always_comb begin
    done_o   = 1'b0;
    broken_o = 1'b0;
    armed_d  = armed_q;
    if (wr_i) begin
      if (data_i == KEY_ARM) begin
        armed_d = 1'b1;
      end else if (data_i == KEY_FIRE && armed_q) begin
        done_o  = 1'b1;
        armed_d = 1'b0;
      end else begin
        broken_o = 1'b1;
        armed_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R5: the sequencer arms only after a first-key write
  assert_arm_by_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(wr_i && data_i == KEY_ARM));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             underflow_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    underflow_o = run_i && tick_i && !load_i && (cnt_q == '0);
    if (!run_i || load_i || underflow_o) cnt_d = top_i;
    else if (tick_i)                     cnt_d = cnt_q - 1'b1;
    else                                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R10: count moves only on a tick, a reload or while stopped
  assert_count_moves_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> $past(tick_i || load_i || !run_i));
  // R8: an underflow leaves the reload value in the counter
  assert_underflow_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> (cnt_q == $past(top_i)));
endmodule

// File: rtl/winwdt.sv
module winwdt
  import winwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_sel_i,
  input  logic [CFG_W-1:0] boot_cfg_i,
  input  logic             bus_wr_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [15:0]      bus_wdata_i,
  output logic [15:0]      bus_rdata_o,
  output logic             rst_o,
  output logic             irq_o
);
  localparam logic [1:0] A_REFRESH = 2'd0;
  localparam logic [1:0] A_CTRL    = 2'd1;
  localparam logic [1:0] A_STATUS  = 2'd2;

  wdt_cfg_t         boot_q, sw_q, eff;
  logic             latched_q, regmode_q, started_q, uf_flag_q, err_flag_q, rst_q, irq_q;
  logic             tick, seq_done, seq_broken, underflow, in_win, load, refresh_err, fault;
  logic [CNT_W:0]   per, quarter, win_hi, win_lo;
  logic [CNT_W-1:0] top, cnt;
  logic [PRE_W:0]   ratio;
  logic             ctrl_we;

  // configuration source and derived values
  always_comb begin
    eff     = regmode_q ? sw_q : boot_q;
    per     = period_ticks(eff.period_sel);
    top     = CNT_W'(per - 1'b1);
    ratio   = div_ratio(eff.div_sel);
    quarter = per >> 2;
    case (eff.win_start)
      2'b00:   win_hi = quarter;
      2'b01:   win_hi = quarter << 1;
      2'b10:   win_hi = quarter + (quarter << 1);
      default: win_hi = per;
    endcase
    case (eff.win_end)
      2'b00:   win_lo = quarter + (quarter << 1);
      2'b01:   win_lo = quarter << 1;
      2'b10:   win_lo = quarter;
      default: win_lo = '0;
    endcase
    in_win      = ({1'b0, cnt} < win_hi) && ({1'b0, cnt} >= win_lo);
    load        = seq_done && (!started_q || in_win);
    refresh_err = started_q && ((seq_done && !in_win) || seq_broken);
    fault       = underflow || refresh_err;
    ctrl_we     = bus_wr_i && (bus_addr_i == A_CTRL) && latched_q && regmode_q && !started_q;
  end

  wdt_refresh_seq #(.DATA_W(16)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_i(bus_wr_i && bus_addr_i == A_REFRESH), .data_i(bus_wdata_i),
    .done_o(seq_done), .broken_o(seq_broken)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(started_q), .clr_i(load),
    .ratio_i(ratio), .tick_o(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(started_q), .tick_i(tick), .load_i(load),
    .top_i(top), .cnt_o(cnt), .underflow_o(underflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_q  <= 1'b0;
      regmode_q  <= 1'b0;
      boot_q     <= '0;
      sw_q       <= '0;
      started_q  <= 1'b0;
      uf_flag_q  <= 1'b0;
      err_flag_q <= 1'b0;
      rst_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (!latched_q) begin
        latched_q <= 1'b1;
        regmode_q <= boot_sel_i;
        boot_q    <= wdt_cfg_t'(boot_cfg_i);
      end
      if (ctrl_we) sw_q <= wdt_cfg_t'(bus_wdata_i[CFG_W-1:0]);
      if (latched_q && !started_q && (!regmode_q || seq_done)) started_q <= 1'b1;
      if (underflow)   uf_flag_q  <= 1'b1;
      if (refresh_err) err_flag_q <= 1'b1;
      rst_q <= fault && !eff.fault_irq;
      irq_q <= fault && eff.fault_irq;
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_CTRL:   bus_rdata_o = {{(16-CFG_W){1'b0}}, eff};
      A_STATUS: bus_rdata_o = {err_flag_q, uf_flag_q, cnt};
      default:  bus_rdata_o = '0;
    endcase
  end

  assign rst_o = rst_q;
  assign irq_o = irq_q;

  // R1/R2: configuration in effect is frozen once counting runs
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(started_q) |-> $stable(eff));
  // R9: reset and interrupt requests are exclusive
  assert_single_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_o && irq_o));
  // R9: interrupt only when selected in the previous cycle
  assert_irq_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(eff.fault_irq));
endmodule

// File: tb/tb_winwdt.sv
module tb_winwdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_sel = 1'b1;
  logic [10:0] boot_cfg = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rst_o, irq_o;

  int checks = 0, fails = 0, n_rst = 0, n_irq = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  winwdt dut (
    .clk(clk), .rst_n(rst_n), .boot_sel_i(boot_sel), .boot_cfg_i(boot_cfg),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .rst_o(rst_o), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    if (rst_o) n_rst++;
    if (irq_o) n_irq++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic refresh();
    bus_write(2'd0, 16'h0000);
    bus_write(2'd0, 16'h00FF);
  endtask

  task automatic do_reset(input logic sel, input logic [10:0] cfg);
    rst_n = 1'b0; boot_sel = sel; boot_cfg = cfg;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  // register mode, timeout, ignored control writes, interrupt select
  task automatic t_reg_mode();
    logic [15:0] rd;
    int base, cyc;
    do_reset(1'b1, 11'h000);
    chk(rst_o == 0 && irq_o == 0, "R9 outputs idle after reset", int'(rst_o | irq_o), 0);
    bus_write(2'd1, 16'h07C4);
    bus_read(2'd2, rd);
    chk(rd[13:0] == 14'd1023, "R3 stopped count reads reload", int'(rd[13:0]), 1023);
    bus_read(2'd1, rd);
    chk(rd == 16'h07C4, "R2 control accepted before start", int'(rd), 'h7C4);
    refresh();
    wait_cyc(100);
    bus_read(2'd2, rd);
    chk(rd[13:0] >= 14'd990 && rd[13:0] <= 14'd1000, "R5 counting after first refresh", int'(rd[13:0]), 995);
    bus_write(2'd1, 16'h0000);
    bus_read(2'd1, rd);
    chk(rd == 16'h07C4, "R2 control write ignored after start", int'(rd), 'h7C4);
    base = n_irq;
    refresh();
    cyc = 0;
    while (n_irq == base && cyc < 6000) begin
      @(negedge clk); cyc++;
    end
    chk(cyc >= 4085 && cyc <= 4110, "R8 underflow after 1024 ticks of 4", cyc, 4096);
    chk(n_rst == 0, "R9 no reset request when irq selected", n_rst, 0);
    bus_read(2'd2, rd);
    chk(rd[14] == 1'b1 && rd[15] == 1'b0, "R8 underflow flag set", int'(rd[15:14]), 1);
    chk(rd[13:0] >= 14'd1015, "R8 counter reloaded after underflow", int'(rd[13:0]), 1023);
  endtask

  // window start bound and sequence errors
  task automatic t_window_start();
    logic [15:0] rd;
    int base;
    do_reset(1'b1, 11'h000);
    bus_write(2'd1, 16'h05C4);
    refresh();
    base = n_irq;
    refresh();
    wait_cyc(3);
    chk(n_irq == base + 1, "R6 refresh above start bound is an error", n_irq - base, 1);
    bus_read(2'd2, rd);
    chk(rd[15] == 1'b1, "R7 refresh error flag", int'(rd[15]), 1);
    wait_cyc(2100);
    bus_read(2'd2, rd);
    chk(rd[13:0] < 14'd512, "R6 count inside window", int'(rd[13:0]), 500);
    base = n_irq;
    refresh();
    wait_cyc(3);
    bus_read(2'd2, rd);
    chk(n_irq == base, "R6 refresh inside window accepted", n_irq - base, 0);
    chk(rd[13:0] >= 14'd1018, "R5 valid refresh reloads counter", int'(rd[13:0]), 1023);
    base = n_irq;
    bus_write(2'd0, 16'h0000);
    bus_write(2'd0, 16'h0055);
    wait_cyc(3);
    chk(n_irq == base + 1, "R7 broken sequence is an error", n_irq - base, 1);
    base = n_irq;
    bus_write(2'd0, 16'h00FF);
    wait_cyc(3);
    chk(n_irq == base + 1, "R7 unarmed second key is an error", n_irq - base, 1);
  endtask

  // window end bound
  task automatic t_window_end();
    int base;
    do_reset(1'b1, 11'h000);
    bus_write(2'd1, 16'h0704);
    refresh();
    base = n_irq;
    refresh();
    wait_cyc(3);
    chk(n_irq == base, "R6 refresh above end bound accepted", n_irq - base, 0);
    wait_cyc(1200);
    base = n_irq;
    refresh();
    wait_cyc(3);
    chk(n_irq == base + 1, "R6 refresh below end bound is an error", n_irq - base, 1);
  endtask

  // auto mode from boot word, reset output
  task automatic t_auto_mode();
    logic [15:0] rd;
    int base, cyc;
    base = n_rst;
    do_reset(1'b0, 11'h3C4);
    boot_cfg = 11'h7FF;
    bus_write(2'd1, 16'h0000);
    bus_read(2'd1, rd);
    chk(rd == 16'h03C4, "R1 boot word in effect, writes ignored", int'(rd), 'h3C4);
    wait_cyc(100);
    bus_read(2'd2, rd);
    chk(rd[13:0] < 14'd1000 && rd[13:0] > 14'd960, "R1 counting started without refresh", int'(rd[13:0]), 996);
    cyc = 0;
    while (n_rst == base && cyc < 6000) begin
      @(negedge clk); cyc++;
    end
    chk(cyc >= 3950 && cyc <= 4010, "R9 reset request on underflow", cyc, 3990);
    chk(irq_o == 0, "R9 no irq when reset selected", int'(irq_o), 0);
  endtask

  // reserved division holds the counter, period code 01 reload
  task automatic t_reserved_div();
    logic [15:0] rd;
    do_reset(1'b1, 11'h000);
    bus_write(2'd1, 16'h07C1);
    bus_read(2'd2, rd);
    chk(rd[13:0] == 14'h0FFF, "R3 period code 01 reloads 0FFFh", int'(rd[13:0]), 'hFFF);
    refresh();
    wait_cyc(500);
    bus_read(2'd2, rd);
    chk(rd[13:0] == 14'h0FFF, "R4 reserved division holds count", int'(rd[13:0]), 'hFFF);
  endtask

  // divide by 64: one step per 64 clocks, stable between ticks
  task automatic t_div64();
    logic [15:0] rd;
    logic [13:0] prev;
    int changes = 0;
    bit one_step = 1'b1;
    do_reset(1'b1, 11'h000);
    bus_write(2'd1, 16'h07D1);
    refresh();
    bus_read(2'd2, rd);
    prev = rd[13:0];
    for (int i = 0; i < 640; i++) begin
      bus_read(2'd2, rd);
      if (rd[13:0] != prev) begin
        changes++;
        if (rd[13:0] != prev - 14'd1) one_step = 1'b0;
        prev = rd[13:0];
      end
    end
    chk(changes >= 9 && changes <= 11, "R4 divide-by-64 tick rate", changes, 10);
    chk(one_step, "R10 count steps by one per tick", int'(one_step), 1);
  endtask

  initial begin
    t_reg_mode();
    t_window_start();
    t_window_end();
    t_auto_mode();
    t_reserved_div();
    t_div64();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule